// File: doc/BRIEF.md
# Pointer-Addressed Serial-Bus Target

This block is a target (slave) on a two-wire serial bus. It runs from a fast system clock and oversamples the bus clock and data lines. It never drives the data line high. Its only output is an active-low pull-down enable for an open-drain pad. The block recognises start, repeated-start and stop conditions, answers one fixed 7-bit device address, and holds a 16 x 8 register file.

In a write transfer, the first byte after the address sets an internal register pointer. Every further byte goes into the register that the pointer selects, and the pointer then steps forward. A read transfer carries no command byte. It streams registers out from wherever an earlier write left the pointer, and continues until the master answers a byte with a no-acknowledge. A repeated start keeps the pointer, so the usual sequence is a write of the pointer, a repeated start, and then a read.

Top module: `smb_ptr_target`

## Requirements
- R1: A start is SDA falling while SCL is high. A repeated start seen in any state begins a new address phase, releases SDA and keeps the pointer value.
- R2: After a start the block shifts in 8 bits, most significant first, sampled while SCL is high: a 7-bit address (default 7'h2C) and a direction bit (0 write, 1 read). On a match it pulls SDA low from just after the 8th SCL falling edge until just after the 9th.
- R3: On an address mismatch the block keeps SDA released through all later bytes until the next start.
- R4: In a write, the first byte after the address is acknowledged and its low 4 bits load the pointer; the upper 4 bits are ignored.
- R5: Each later write byte is acknowledged and stored in the register that the pointer selects.
- R6: In a read, each byte is the content of the register that the pointer selects, driven most significant bit first, with SDA changing only while SCL is low.
- R7: The pointer advances by one after each data byte written or read, and wraps from 15 to 0.
- R8: When the master does not acknowledge a read byte (SDA high on the 9th clock), the block releases SDA and stays released until a stop or a start.
- R9: A stop (SDA rising while SCL is high) aborts any transfer, releases SDA and leaves an unfinished byte unwritten.
- R10: After reset SDA is released, all registers read 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_n | output | 1 | Active-low pull-down enable for SDA (0 pulls the line low) |

## Verification
A table of single-register writes is each read back through a write of the pointer, a repeated start and a read. The table holds bytes with all bits low, all bits high and alternating bits, which exposes bit-order and shift errors. One pointer byte has its upper bits set, to show that only the low bits select a register. A burst that starts at register 14 checks the pointer step and the wrap from 15 to 0. A foreign address, a no-acknowledged read followed by extra clocks, and a write cut off by a stop each have to leave the line quiet or the register unchanged. Together these cases separate a target that only decodes addresses from one that also tracks its state correctly.

// File: rtl/smb_tgt_pkg.sv
// Package: shared types for the pointer-addressed serial-bus target.
// Assumes nothing beyond IEEE 1800-2017.
package smb_tgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_SKIP
    } tgt_state_t;
endpackage

// File: rtl/smb_line_sync.sv
// Module: smb_line_sync
// Brings one asynchronous bus line into the system clock domain through a
// chain of flops and also gives the value one clock older, for edge detection.
// Assumes the line idles high (pulled up), so the reset value is 1.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s,
    output logic line_d
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain  <= '1;
            line_d <= 1'b1;
        end else begin
            chain  <= {chain[STAGES-2:0], line_i};
            line_d <= chain[STAGES-1];
        end
    end

    assign line_s = chain[STAGES-1];
endmodule

// File: rtl/smb_ptr_regs.sv
// Module: smb_ptr_regs
// Register file with an address pointer. The pointer can be loaded, or it
// steps by one with wrap-around. Assumes load and advance are never requested
// in the same cycle. The read data always shows the register under the pointer.
module smb_ptr_regs #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_val,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          adv,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [NREG];
    logic [AW-1:0] ptr;

    // Pointer: load from a command byte, or step after each data byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr <= '0;
        else if (ptr_load) ptr <= ptr_val;
        else if (adv)      ptr <= (ptr == AW'(NREG-1)) ? '0 : ptr + 1'b1;
    end

    // Storage: clear on reset, write the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[ptr] <= wdata;
        end
    end

    assign rdata = mem[ptr];

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ptr_load && ptr == AW'(NREG-1)) |=> (ptr == '0)); // R7
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> (ptr == $past(ptr_val))); // R4
endmodule

// File: rtl/smb_ptr_target.sv
// Module: smb_ptr_target
// Serial-bus target with a fixed device address and a pointer-addressed
// register file. It oversamples SCL/SDA, decodes start/stop, and drives SDA
// only through an active-low pull-down enable. It assumes the system clock is
// fast enough that each SCL phase lasts several system clocks.
module smb_ptr_target #(
    parameter logic [6:0] DEV_ADDR = 7'h2C,
    parameter int         NREG     = 16,
    parameter int         DW       = 8,
    parameter int         SYNC_STG = 2,
    localparam int        AW       = $clog2(NREG),
    localparam int        CW       = $clog2(DW + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_n
);
    import smb_tgt_pkg::*;

    logic scl_s, scl_d, sda_s, sda_d;
    logic start_det, stop_det, scl_rise, scl_fall;
    tgt_state_t st;
    logic [CW-1:0] cnt;
    logic [DW-1:0] shreg;
    logic          rw, first, mack;
    logic          ptr_load, wr_en, rd_load, adv;
    logic [DW-1:0] rdata;

    smb_line_sync #(.STAGES(SYNC_STG)) i_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_s(scl_s), .line_d(scl_d));
    smb_line_sync #(.STAGES(SYNC_STG)) i_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_s(sda_s), .line_d(sda_d));

    // Bus events decoded from the synchronized lines.
    assign start_det = scl_s && scl_d && sda_d && !sda_s;
    assign stop_det  = scl_s && scl_d && !sda_d && sda_s;
    assign scl_rise  = scl_s && !scl_d;
    assign scl_fall  = !scl_s && scl_d;

    // Register-file controls, taken at the SCL fall that ends a byte.
    always_comb begin
        logic evt;
        evt      = scl_fall && !start_det && !stop_det;
        ptr_load = evt && st == ST_WR_BYTE && cnt == CW'(DW) && first;
        wr_en    = evt && st == ST_WR_BYTE && cnt == CW'(DW) && !first;
        rd_load  = evt && ((st == ST_ADDR_ACK && rw) || (st == ST_RD_ACK && mack));
        adv      = wr_en || rd_load;
    end

    smb_ptr_regs #(.NREG(NREG), .DW(DW)) i_regs (
        .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_val(shreg[AW-1:0]),
        .wr_en(wr_en), .wdata(shreg), .adv(adv), .rdata(rdata));

    // Protocol sequencer: shifts bits in on SCL rise and drives SDA after SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; cnt <= '0; shreg <= '0;
            rw <= 1'b0; first <= 1'b0; mack <= 1'b0; sda_oe_n <= 1'b1;
        end else if (start_det) begin
            st <= ST_ADDR; cnt <= '0; sda_oe_n <= 1'b1;
        end else if (stop_det) begin
            st <= ST_IDLE; sda_oe_n <= 1'b1;
        end else begin
            case (st)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise && cnt < CW'(DW)) begin
                        shreg <= {shreg[DW-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end else if (scl_fall && cnt == CW'(DW)) begin
                        if (st == ST_WR_BYTE) begin
                            st <= ST_WR_ACK; sda_oe_n <= 1'b0;
                        end else if (shreg[7:1] == DEV_ADDR) begin
                            st <= ST_ADDR_ACK; rw <= shreg[0]; sda_oe_n <= 1'b0;
                        end else begin
                            st <= ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw) begin
                            st <= ST_RD_BYTE; shreg <= rdata;
                            sda_oe_n <= rdata[DW-1]; cnt <= CW'(1);
                        end else begin
                            st <= ST_WR_BYTE; cnt <= '0; first <= 1'b1; sda_oe_n <= 1'b1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        st <= ST_WR_BYTE; cnt <= '0; first <= 1'b0; sda_oe_n <= 1'b1;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        if (cnt == CW'(DW)) begin
                            st <= ST_RD_ACK; sda_oe_n <= 1'b1;
                        end else begin
                            shreg    <= {shreg[DW-2:0], 1'b0};
                            sda_oe_n <= shreg[DW-2];
                            cnt      <= cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) mack <= !sda_s;
                    else if (scl_fall) begin
                        if (mack) begin
                            st <= ST_RD_BYTE; shreg <= rdata;
                            sda_oe_n <= rdata[DW-1]; cnt <= CW'(1);
                        end else begin
                            st <= ST_SKIP; sda_oe_n <= 1'b1;
                        end
                    end
                end
                default: sda_oe_n <= 1'b1;
            endcase
        end
    end

    AST_ADDR_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR_ACK) |-> !sda_oe_n); // R2
    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |-> sda_oe_n); // R3
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> sda_oe_n); // R9
    AST_HIGH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det))
        |-> $stable(sda_oe_n)); // R6
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (sda_oe_n && st == ST_ADDR)); // R1
endmodule

// File: tb/test_smb_ptr_target.sv
module test_smb_ptr_target;
    localparam int Q = 10;
    localparam logic [7:0] WADDR = {7'h2C, 1'b0};
    localparam logic [7:0] RADDR = {7'h2C, 1'b1};
    // Each entry: {pointer byte, data byte}
    localparam logic [15:0] VEC [6] = '{16'h005A, 16'h07C3, 16'h0F81,
                                        16'hF33C, 16'h09FF, 16'h0400};

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
    logic sda_oe_n, sda_line, quiet = 1'b0, done = 1'b0;
    int checks = 0, errors = 0, quiet_hits = 0;
    logic [7:0] exp_mem [16];

    assign sda_line = sda_m & sda_oe_n;
    always #4 clk = ~clk;

    smb_ptr_target i_smb_ptr_target (.clk(clk), .rst_n(rst_n), .scl_i(scl),
        .sda_i(sda_line), .sda_oe_n(sda_oe_n));

    always @(negedge clk) if (quiet && !sda_oe_n) quiet_hits++;

    task automatic qw(input int n = 1);
        repeat (n * Q) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qw(); scl = 1'b1; qw(2); scl = 1'b0; qw();
        end
        sda_m = 1'b1; qw(); scl = 1'b1; qw(); ack = !sda_line; qw(); scl = 1'b0; qw();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw(); scl = 1'b1; qw(); b[i] = sda_line; qw(); scl = 1'b0; qw();
        end
        sda_m = !give_ack; qw(); scl = 1'b1; qw(2); scl = 1'b0; qw(); sda_m = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        bus_start(); send_byte(WADDR, a); chk("R2 write address ack", {7'd0, a}, 8'd1);
        send_byte(p, a); chk("R4 pointer byte ack", {7'd0, a}, 8'd1);
    endtask

    initial begin
        logic a;
        logic [7:0] d;
        for (int i = 0; i < 16; i++) exp_mem[i] = 8'h00;
        qw(2);
        chk("R10 SDA released in reset", {7'd0, sda_oe_n}, 8'd1);
        rst_n = 1'b1; qw();
        chk("R10 SDA released after reset", {7'd0, sda_oe_n}, 8'd1);

        // R10: register 6 reads zero after reset
        set_ptr(8'h06); bus_start(); send_byte(RADDR, a);
        recv_byte(1'b0, d); bus_stop();
        chk("R10 register cleared", d, 8'h00);

        // Table: write one register, read it back via repeated start (R4 R5 R6 R1)
        for (int v = 0; v < 6; v++) begin
            set_ptr(VEC[v][15:8]); send_byte(VEC[v][7:0], a);
            chk("R5 data byte ack", {7'd0, a}, 8'd1);
            bus_stop();
            exp_mem[VEC[v][11:8]] = VEC[v][7:0];
            set_ptr(VEC[v][15:8]); bus_start(); send_byte(RADDR, a);
            chk("R1 address ack after repeated start", {7'd0, a}, 8'd1);
            recv_byte(1'b0, d); bus_stop();
            chk("R6 R4 read back", d, exp_mem[VEC[v][11:8]]);
        end

        // R7: burst write from 14 wraps to 0, read back in one burst
        set_ptr(8'h0E);
        send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a); bus_stop();
        exp_mem[14] = 8'h11; exp_mem[15] = 8'h22; exp_mem[0] = 8'h33;
        set_ptr(8'h0E); bus_start(); send_byte(RADDR, a);
        recv_byte(1'b1, d); chk("R7 burst byte 14", d, 8'h11);
        recv_byte(1'b1, d); chk("R7 burst byte 15", d, 8'h22);
        recv_byte(1'b0, d); chk("R7 wrap to register 0", d, 8'h33);
        bus_stop();

        // R1: pointer kept across repeated start; reads continue after previous read
        set_ptr(8'h03); bus_start(); send_byte(RADDR, a);
        recv_byte(1'b0, d); bus_start(); send_byte(RADDR, a);
        recv_byte(1'b0, d); bus_stop();
        chk("R1 R7 pointer kept across repeated start", d, exp_mem[4]);

        // R3: foreign address, then data bytes; line must stay quiet
        bus_start(); send_byte({7'h2D, 1'b0}, a);
        chk("R3 no ack on mismatch", {7'd0, a}, 8'd0);
        quiet = 1'b1; quiet_hits = 0;
        send_byte(8'h01, a); send_byte(8'hAA, a);
        quiet = 1'b0; bus_stop();
        chk("R3 SDA quiet after mismatch", quiet_hits[7:0], 8'd0);
        set_ptr(8'h01); bus_start(); send_byte(RADDR, a);
        recv_byte(1'b0, d); bus_stop();
        chk("R3 register untouched", d, exp_mem[1]);

        // R8: no-acknowledge ends the read; further clocks see a released line
        set_ptr(8'h09); bus_start(); send_byte(RADDR, a);
        recv_byte(1'b0, d);
        quiet = 1'b1; quiet_hits = 0;
        recv_byte(1'b0, d);
        quiet = 1'b0; bus_stop();
        chk("R8 released after no-ack", quiet_hits[7:0], 8'd0);
        chk("R8 extra clocks read all ones", d, 8'hFF);

        // R9: stop in the middle of a data byte leaves register 5 unchanged
        set_ptr(8'h05);
        for (int i = 0; i < 4; i++) begin
            sda_m = 1'b0; qw(); scl = 1'b1; qw(2); scl = 1'b0; qw();
        end
        bus_stop();
        chk("R9 SDA released after stop", {7'd0, sda_oe_n}, 8'd1);
        bus_start(); send_byte(RADDR, a);
        recv_byte(1'b0, d); bus_stop();
        chk("R9 aborted byte not written", d, exp_mem[5]);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule